// File: doc/BRIEF.md
# Oversampled Full-Duplex UART Core

This block sends and receives asynchronous serial characters at the same time. A character on the line is ten bits long. The first bit is a low start bit, the next eight bits carry the payload least significant bit first, and the last bit is a high stop bit. Bit timing comes from an external pulse such as a timer overflow. An optional divide-by-2 stage slows that pulse, and a free-running sixteen-phase counter then divides it further. Each bit therefore lasts 16 or 32 input pulses.

A transmission is requested by a write to the buffer. The write does not start the line right away. The start bit appears at the next wrap of the free-running counter, and every later bit edge falls on a wrap as well. The receiver hunts for a falling edge on its line and starts its own sixteen-phase count at that edge. It votes on three samples around the middle of each bit. When a character completes, the receiver loads the received byte and the observed stop level into readable outputs, but only if the previous character has been taken and reception is enabled. Each direction has a done flag with its own clear input.

Top module: `uart_fd_core`

## Requirements
- R1: After reset, `txd_o` is 1 and `tx_done_o`, `rx_done_o`, `stop_bit_o` and `rd_data_o` are all 0.
- R2: A transmitted character is a 0 start bit, then `wr_data_i[0]` through `wr_data_i[7]` in that order, then a 1 stop bit. `txd_o` is 1 whenever no character is on the line.
- R3: With `rate_half_i` = 0 every bit lasts 16 `baud_tick_i` pulses. With `rate_half_i` = 1 every bit lasts 32 pulses. Only every second pulse advances the phase counter.
- R4: The phase counter runs freely from reset and wraps each time the count of `baud_tick_i` pulses since reset reaches a multiple of 16 (or 32 at half rate). The start bit goes out at the first wrap strictly after the write cycle.
- R5: Each later bit of the character, and the return to idle, changes `txd_o` at the next wrap and at no other time.
- R6: A write that arrives while a character is waiting or still on the line (including its stop bit) is ignored and produces no second character.
- R7: `tx_done_o` rises on the cycle the stop bit is driven. It stays high until a `tx_done_clr_i` pulse, and setting wins over clearing in the same cycle.
- R8: A falling edge on `rxd_i` starts reception. Each bit is decided by a 2-of-3 majority of samples taken at phases 7, 8 and 9 of the receiver's own count. A start bit that votes 1 abandons the character, and a disturbance shorter than the vote window does not change a bit.
- R9: A completed character puts its eight bits, first received in bit 0, on `rd_data_o`. It puts the voted stop level on `stop_bit_o` and sets `rx_done_o`.
- R10: If `rx_done_o` is already high or `rx_enable_i` is 0 when the stop bit is voted, the character is dropped and `rd_data_o`, `stop_bit_o` and `rx_done_o` keep their values.
- R11: Transmission and reception run at the same time without affecting each other.
- R12: A `rx_done_clr_i` pulse clears `rx_done_o` when no character completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick_i | input | 1 | Timing pulse, one clock wide |
| rate_half_i | input | 1 | 1 selects 32 pulses per bit, 0 selects 16 |
| wr_en_i | input | 1 | Buffer write strobe requesting a transmission |
| wr_data_i | input | 8 | Byte to send |
| rd_data_o | output | 8 | Last byte accepted by the receiver |
| rx_enable_i | input | 1 | Allows completed characters to be accepted |
| tx_done_o | output | 1 | Transmit done flag |
| tx_done_clr_i | input | 1 | Clears the transmit done flag |
| rx_done_o | output | 1 | Receive done flag |
| rx_done_clr_i | input | 1 | Clears the receive done flag |
| stop_bit_o | output | 1 | Stop level of the last accepted character |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |

## Verification
The assertions hold cycle by cycle for these rules: the line output moves only on a counter wrap, the done flags are set and cleared correctly, received data stays frozen while the receive flag is up, and the half-rate path drops every other pulse. Other behaviour can only be shown from the bench's scenarios. That includes the exact tick count at which a start bit appears for a given write time, the bit order on the line and in the buffer, and whether a glitch is rejected or accepted by the vote. It also includes dropped characters and full-duplex operation. These are checked against arithmetic the bench computes from its own count of pulses since reset.

// File: rtl/uart_fd_pkg.sv
package uart_fd_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  typedef enum logic {
    RX_HUNT  = 1'b0,
    RX_FRAME = 1'b1
  } rx_state_e;

  // 2-of-3 majority of three line samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // first of the three vote phases for a given oversampling rate
  function automatic int unsigned vote_first(input int unsigned os_rate);
    return os_rate / 2 - 1;
  endfunction

endpackage

// File: rtl/uart_fd_rate.sv
module uart_fd_rate #(
  parameter int unsigned OS_RATE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic half_i,
  output logic os_tick_o,
  output logic roll_o
);
  localparam int unsigned PH_W = $clog2(OS_RATE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS_RATE - 1);

  logic            half_q;
  logic [PH_W-1:0] ph_q;

  // divide-by-2 stage: in half mode only every second pulse passes
  assign os_tick_o = tick_i & (~half_i | half_q);
  assign roll_o    = os_tick_o & (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      if (tick_i) half_q <= ~half_q;
      if (os_tick_o) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/uart_fd_tx.sv
module uart_fd_tx
  import uart_fd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic              txd_o,
  output logic              done_o,
  output logic              accept_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              busy_o
);
  localparam int unsigned FRAME_N = DATA_W + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_N);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_N - 1);
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(FRAME_N - 2);

  tx_state_e          st_q;
  logic [FRAME_N-1:0] frame_q;
  logic [FRAME_N-1:0] frame_d;
  logic [IDX_W-1:0]   idx_q;

  assign frame_d[0]         = 1'b0;
  assign frame_d[FRAME_N-1] = 1'b1;
  for (genvar g = 0; g < DATA_W; g++) begin : g_frame
    assign frame_d[g+1] = wr_data_i[g];
  end

  assign accept_o = wr_i & (st_q == TX_IDLE);
  assign start_o  = roll_i & (st_q == TX_WAIT);
  assign stop_o   = roll_i & (st_q == TX_SEND) & (idx_q == IDX_PRE);
  assign busy_o   = (st_q != TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      frame_q <= '1;
      idx_q   <= '0;
      txd_o   <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (wr_i) begin
            frame_q <= frame_d;
            st_q    <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (roll_i) begin
            txd_o   <= frame_q[0];
            frame_q <= {1'b1, frame_q[FRAME_N-1:1]};
            idx_q   <= '0;
            st_q    <= TX_SEND;
          end
        end
        default: begin
          if (roll_i) begin
            if (idx_q == IDX_LAST) begin
              txd_o <= 1'b1;
              st_q  <= TX_IDLE;
            end else begin
              txd_o   <= frame_q[0];
              frame_q <= {1'b1, frame_q[FRAME_N-1:1]};
              idx_q   <= idx_q + IDX_W'(1);
            end
          end
        end
      endcase
      if (stop_o)     done_o <= 1'b1;
      else if (clr_i) done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fd_rx.sv
module uart_fd_rx
  import uart_fd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o,
  output logic              done_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              load_o
);
  localparam int unsigned PH_W    = $clog2(OS_RATE);
  localparam int unsigned FRAME_N = DATA_W + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_N);
  localparam logic [PH_W-1:0]  PH_V0   = PH_W'(vote_first(OS_RATE));
  localparam logic [PH_W-1:0]  PH_V1   = PH_W'(vote_first(OS_RATE) + 1);
  localparam logic [PH_W-1:0]  PH_V2   = PH_W'(vote_first(OS_RATE) + 2);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_N - 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_W);

  logic [1:0]        sync_q;
  logic              rx_s;
  logic              last_q;
  rx_state_e         st_q;
  logic [PH_W-1:0]   ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        votes_q;
  logic [DATA_W-1:0] shift_q;
  logic              decide;
  logic              bit_val;
  logic              frame_end;

  assign rx_s      = sync_q[1];
  assign start_o   = os_tick_i & (st_q == RX_HUNT) & last_q & ~rx_s;
  assign decide    = os_tick_i & (st_q == RX_FRAME) & (ph_q == PH_V2);
  assign bit_val   = vote3({rx_s, votes_q});
  assign abort_o   = decide & (idx_q == '0) & bit_val;
  assign frame_end = decide & (idx_q == IDX_END);
  assign load_o    = frame_end & en_i & ~done_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      last_q  <= 1'b1;
      st_q    <= RX_HUNT;
      ph_q    <= '0;
      idx_q   <= '0;
      votes_q <= '0;
      shift_q <= '0;
      data_o  <= '0;
      stop_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (os_tick_i) last_q <= rx_s;
      if (st_q == RX_HUNT) begin
        if (start_o) begin
          st_q  <= RX_FRAME;
          ph_q  <= '0;
          idx_q <= '0;
        end
      end else if (os_tick_i) begin
        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
        if (ph_q == PH_LAST) idx_q <= idx_q + IDX_W'(1);
        if (ph_q == PH_V0) votes_q[0] <= rx_s;
        if (ph_q == PH_V1) votes_q[1] <= rx_s;
        if (ph_q == PH_V2) begin
          if (abort_o) begin
            st_q <= RX_HUNT;
          end else if (idx_q == IDX_END) begin
            st_q <= RX_HUNT;
            if (load_o) begin
              data_o <= shift_q;
              stop_o <= bit_val;
            end
          end else if (idx_q != '0 && idx_q <= IDX_MAX) begin
            shift_q <= {bit_val, shift_q[DATA_W-1:1]};
          end
        end
      end
      if (load_o)     done_o <= 1'b1;
      else if (clr_i) done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fd_core.sv
module uart_fd_core #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick_i,
  input  logic              rate_half_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rx_enable_i,
  output logic              tx_done_o,
  input  logic              tx_done_clr_i,
  output logic              rx_done_o,
  input  logic              rx_done_clr_i,
  output logic              stop_bit_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  // internal events, named for the checker
  logic os_tick;
  logic bit_roll;
  logic tx_accept;
  logic tx_start;
  logic tx_stop_evt;
  logic tx_busy;
  logic rx_start;
  logic rx_abort;
  logic rx_load;

  uart_fd_rate #(.OS_RATE(OS_RATE)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (baud_tick_i),
    .half_i   (rate_half_i),
    .os_tick_o(os_tick),
    .roll_o   (bit_roll)
  );

  uart_fd_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .roll_i   (bit_roll),
    .wr_i     (wr_en_i),
    .wr_data_i(wr_data_i),
    .clr_i    (tx_done_clr_i),
    .txd_o    (txd_o),
    .done_o   (tx_done_o),
    .accept_o (tx_accept),
    .start_o  (tx_start),
    .stop_o   (tx_stop_evt),
    .busy_o   (tx_busy)
  );

  uart_fd_rx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick_i(os_tick),
    .rxd_i    (rxd_i),
    .en_i     (rx_enable_i),
    .clr_i    (rx_done_clr_i),
    .data_o   (rd_data_o),
    .stop_o   (stop_bit_o),
    .done_o   (rx_done_o),
    .start_o  (rx_start),
    .abort_o  (rx_abort),
    .load_o   (rx_load)
  );
endmodule

// File: rtl/uart_fd_chk.sv
module uart_fd_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_tick_i,
  input logic              rate_half_i,
  input logic              rx_enable_i,
  input logic              tx_done_clr_i,
  input logic              rx_done_clr_i,
  input logic              txd_o,
  input logic              tx_done_o,
  input logic              rx_done_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              stop_bit_o,
  input logic              os_tick,
  input logic              bit_roll,
  input logic              tx_accept,
  input logic              tx_start,
  input logic              tx_stop_evt,
  input logic              rx_start,
  input logic              rx_abort,
  input logic              rx_load
);
  a_r1_idle_high_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> txd_o);

  a_r3_os_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> baud_tick_i);

  a_r3_half_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_half_i && os_tick) |-> !$past(os_tick));

  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !txd_o);

  a_r5_line_moves_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_o) |-> $past(bit_roll));

  a_r5_roll_on_os_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_roll |-> os_tick);

  a_r7_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_evt |=> tx_done_o && txd_o);

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_o && !tx_done_clr_i) |=> tx_done_o);

  a_r8_rx_events_on_os_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start || rx_abort) |-> os_tick);

  a_r9_done_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done_o) |-> $past(rx_load));

  a_r10_frozen_while_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_done_o) |-> ($stable(rd_data_o) && $stable(stop_bit_o)));

  a_r10_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done_o) |-> $past(rx_enable_i));

  a_r12_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_clr_i && !rx_load) |=> !rx_done_o);
endmodule

bind uart_fd_core uart_fd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .baud_tick_i  (baud_tick_i),
  .rate_half_i  (rate_half_i),
  .rx_enable_i  (rx_enable_i),
  .tx_done_clr_i(tx_done_clr_i),
  .rx_done_clr_i(rx_done_clr_i),
  .txd_o        (txd_o),
  .tx_done_o    (tx_done_o),
  .rx_done_o    (rx_done_o),
  .rd_data_o    (rd_data_o),
  .stop_bit_o   (stop_bit_o),
  .os_tick      (os_tick),
  .bit_roll     (bit_roll),
  .tx_accept    (tx_accept),
  .tx_start     (tx_start),
  .tx_stop_evt  (tx_stop_evt),
  .rx_start     (rx_start),
  .rx_abort     (rx_abort),
  .rx_load      (rx_load)
);

// File: tb/uart_fd_core_bench.sv
module uart_fd_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       rate_half = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rx_en = 1'b1;
  logic       txc = 1'b0;
  logic       rxc = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rd_data;
  logic       tx_done, rx_done, stop_bit, txd;

  int n_chk = 0;
  int n_bad = 0;
  int bcnt  = 0;

  uart_fd_core u_uart_fd_core (
    .clk(clk), .rst_n(rst_n), .baud_tick_i(baud_tick), .rate_half_i(rate_half),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .rx_enable_i(rx_en), .tx_done_o(tx_done), .tx_done_clr_i(txc),
    .rx_done_o(rx_done), .rx_done_clr_i(rxc), .stop_bit_o(stop_bit),
    .txd_o(txd), .rxd_i(rxd)
  );

  always #5 clk = ~clk;

  // pulses seen by the design since reset release
  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else if (baud_tick) bcnt <= bcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic half);
    @(negedge clk);
    rst_n = 1'b0;
    rate_half = half;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // send one byte and check every bit edge against the pulse count
  task automatic tx_frame(input logic [7:0] d, input int p, input bit inject);
    logic [9:0] fr;
    int w, s, e;
    bit quiet;
    fr = {1'b1, d, 1'b0};
    @(negedge clk); txc = 1'b1;
    @(negedge clk); txc = 1'b0;
    chk(tx_done == 1'b0, "R7 clear", int'(tx_done), 0);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    w = bcnt;
    e = (w / p + 1) * p;
    while (txd) @(negedge clk);
    s = bcnt;
    chk(s == e, "R4 start at first wrap after write", s, e);
    for (int i = 0; i < 10; i++) begin
      chk(txd == fr[i], "R2 bit value at bit start", int'(txd), int'(fr[i]));
      chk(bcnt == s + i * p, "R3 bit length", bcnt, s + i * p);
      if (i == 8) chk(tx_done == 1'b0, "R7 not set before stop", int'(tx_done), 0);
      if (i == 9) chk(tx_done == 1'b1, "R7 set with stop bit", int'(tx_done), 1);
      if (inject && i == 4) begin
        wr_en = 1'b1; wr_data = ~d;
        @(negedge clk); wr_en = 1'b0;
        repeat (p - 2) @(negedge clk);
      end else begin
        repeat (p - 1) @(negedge clk);
      end
      chk(txd == fr[i], "R5 bit value at bit end", int'(txd), int'(fr[i]));
      @(negedge clk);
    end
    chk(txd == 1'b1, "R2 idle after stop", int'(txd), 1);
    if (inject) begin
      quiet = 1'b1;
      for (int c = 0; c < 2 * p; c++) begin
        @(negedge clk);
        if (!txd) quiet = 1'b0;
      end
      chk(quiet, "R6 write while busy ignored", int'(quiet), 1);
    end
  endtask

  // mode 1: one-cycle flip mid bit 3, mode 2: nine-cycle flip around mid bit 3
  task automatic rx_send(input logic [7:0] d, input logic stopv, input int p, input int mode);
    logic [9:0] fr;
    logic flip;
    fr = {stopv, d, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < p; c++) begin
        flip = 1'b0;
        if (i == 3 && mode == 1 && c == p / 2) flip = 1'b1;
        if (i == 3 && mode == 2 && c >= p / 2 - 4 && c <= p / 2 + 4) flip = 1'b1;
        rxd = fr[i] ^ flip;
        @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  task automatic rx_check(input logic [7:0] d, input logic stopv, input int p,
                          input int mode, input logic [7:0] exp_d);
    rx_send(d, stopv, p, mode);
    chk(rx_done == 1'b1, "R9 done after frame", int'(rx_done), 1);
    chk(rd_data == exp_d, "R9 received byte", int'(rd_data), int'(exp_d));
    chk(stop_bit == stopv, "R9 stop level", int'(stop_bit), int'(stopv));
    rxc = 1'b1;
    @(negedge clk); rxc = 1'b0;
    chk(rx_done == 1'b0, "R12 receive flag cleared", int'(rx_done), 0);
    repeat (p) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    do_reset(1'b0);
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_done == 1'b0, "R1 tx_done", int'(tx_done), 0);
    chk(rx_done == 1'b0, "R1 rx_done", int'(rx_done), 0);
    chk(stop_bit == 1'b0, "R1 stop_bit", int'(stop_bit), 0);
    chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);

    // R11: every byte value sent and received simultaneously
    for (int d = 0; d < 256; d++) begin
      fork
        tx_frame(8'(d), 16, 1'b0);
        rx_check(8'(d) ^ 8'hA5, 1'b1, 16, 0, 8'(d) ^ 8'hA5);
      join
    end

    // R6: second write in mid frame
    tx_frame(8'h3C, 16, 1'b1);

    // R8: short low pulse is a false start
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
    chk(rx_done == 1'b0, "R8 false start abandoned", int'(rx_done), 0);
    chk(rd_data == (8'hFF ^ 8'hA5), "R8 buffer kept after false start",
        int'(rd_data), int'(8'hFF ^ 8'hA5));
    rx_check(8'h4E, 1'b1, 16, 0, 8'h4E);
    // R8: single-cycle glitch is outvoted, long disturbance flips bit 2
    rx_check(8'h4E, 1'b1, 16, 1, 8'h4E);
    rx_check(8'h4E, 1'b1, 16, 2, 8'h4A);

    // R9: low stop level is recorded
    rx_check(8'h96, 1'b0, 16, 0, 8'h96);

    // R10: dropped while flag is up
    rx_send(8'h11, 1'b1, 16, 0);
    chk(rd_data == 8'h11, "R9 byte before drop test", int'(rd_data), 8'h11);
    repeat (16) @(negedge clk);
    rx_send(8'h22, 1'b0, 16, 0);
    chk(rd_data == 8'h11, "R10 no overwrite while done", int'(rd_data), 8'h11);
    chk(stop_bit == 1'b1, "R10 stop kept while done", int'(stop_bit), 1);
    rxc = 1'b1;
    @(negedge clk); rxc = 1'b0;
    repeat (16) @(negedge clk);
    // R10: dropped while disabled
    rx_en = 1'b0;
    rx_send(8'h33, 1'b1, 16, 0);
    chk(rx_done == 1'b0, "R10 disabled no flag", int'(rx_done), 0);
    chk(rd_data == 8'h11, "R10 disabled no load", int'(rd_data), 8'h11);
    rx_en = 1'b1;
    repeat (16) @(negedge clk);

    // R3: half rate, 32 pulses per bit
    do_reset(1'b1);
    for (int k = 0; k < 5; k++) begin
      fork
        tx_frame(8'(8'h5A * k + 8'h81), 32, 1'b0);
        rx_check(8'(8'h3C ^ (k * 37)), 1'b1, 32, 0, 8'(8'h3C ^ (k * 37)));
      join
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule